// File: doc/BRIEF.md
# Configuration Write Side-Effect Controller

This block sits beside a register file and turns configuration writes into control pulses and hold levels for the subsystems those writes affect. Every bus write comes with a side-effect class code for the address being written. Some classes act at once, in the cycle after the write. Others only arm an action that is released on the next update-command strobe, which is the moment buffered settings become active. A few of those deferred actions carry extra conditions.

The affected subsystems are a lock detector, a watchdog timer, a system-clock stability timer, the reference-fault and holdover path of the loop, and the configurable function slots. Pending actions survive any number of further writes. Every armed class is serviced together on one update strobe, and the pending state is then cleared. All outputs are registered. Subsystems receive clean one-cycle pulses, or levels that change on a clock edge.

Top module: `wdet_ctrl`

## Requirements
- R1: A write with class code 1 or 3 makes `lock_unlock` high for exactly the cycle after the write. Writes with any other code (0, 2, 4–15) leave it low.
- R2: A class-1 write raises `lock_hold` from the cycle after the write. It stays high until the cycle after the next update strobe, and in that cycle `lock_restart` pulses for one cycle. A class-3 write does not raise `lock_hold`.
- R3: A class-2 write with `wr_sel_ref` high arms a holdover. On the next update strobe the block waits for a `pfd_tick`. `holdover_req` goes high in the cycle after that tick and falls in the cycle after the following tick, so it spans exactly one phase-detector period.
- R4: A class-2 or class-8 write with `wr_sel_ref` low arms nothing. A class-8 write arms the holdover only when `demap_mode` is high at the time of the write.
- R5: A class-5 write raises `wdog_hold` from the next cycle. The next update strobe clears it and pulses `wdog_resume` for one cycle.
- R6: A class-6 write raises `stab_hold`. `stab_resume` pulses, and `stab_hold` falls, in the cycle after the first clock edge that is both at or after the next update strobe and has `sysclk_locked` high.
- R7: A class-7 write with `wr_func_assigned` high pulses `func_stop` in the next cycle. Any class-7 write arms `func_start`, which pulses in the cycle after the next update strobe.
- R8: Repeated writes to an armed class produce a single service on the next update strobe. An update strobe with nothing armed produces no pulse.
- R9: Classes armed within one update window are all serviced in the same cycle.
- R10: A write in the same cycle as an update strobe is armed for the following update, not for that one.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_class | input | 4 | Side-effect class code of the written address |
| wr_sel_ref | input | 1 | Written register belongs to the selected reference |
| wr_func_assigned | input | 1 | Written register is assigned to a running function |
| upd_stb | input | 1 | Update-command strobe |
| demap_mode | input | 1 | Loop is in demapping mode |
| sysclk_locked | input | 1 | System clock is locked |
| pfd_tick | input | 1 | One-cycle tick per phase-detector period |
| lock_unlock | output | 1 | Force lock detector to unlocked (pulse) |
| lock_hold | output | 1 | Lock detection held off |
| lock_restart | output | 1 | Restart lock detection (pulse) |
| wdog_hold | output | 1 | Watchdog reset and held |
| wdog_resume | output | 1 | Watchdog resumes counting (pulse) |
| stab_hold | output | 1 | Stability timer reset and held |
| stab_resume | output | 1 | Stability timer resumes (pulse) |
| holdover_req | output | 1 | Fault reference and enter holdover |
| func_stop | output | 1 | Stop current function (pulse) |
| func_start | output | 1 | Start new function (pulse) |

## Verification
The hardest case to reach is the stability timer after an update strobe that arrives while the system clock is unlocked. The resume must then be deferred past the strobe, and nothing else should be pending at that point. The bench holds `sysclk_locked` low through the write and the strobe, idles several cycles to show that no resume leaks out, and then raises the lock. The holdover window is handled the same way: the bench drives `pfd_tick` by hand, so it controls exactly which edge opens the one-period request and which edge closes it.

// File: rtl/wdet_pkg.sv
package wdet_pkg;

    localparam int CLASS_W = 4;

    typedef logic [CLASS_W-1:0] wr_class_t;

    localparam wr_class_t CLS_LOCK_RESTART = wr_class_t'(1);
    localparam wr_class_t CLS_HOLDOVER     = wr_class_t'(2);
    localparam wr_class_t CLS_LOCK_DROP    = wr_class_t'(3);
    localparam wr_class_t CLS_WATCHDOG     = wr_class_t'(5);
    localparam wr_class_t CLS_STABILITY    = wr_class_t'(6);
    localparam wr_class_t CLS_FUNCTION     = wr_class_t'(7);
    localparam wr_class_t CLS_HOLDOVER_DM  = wr_class_t'(8);

    typedef enum logic [1:0] {
        HO_IDLE   = 2'd0,
        HO_ALIGN  = 2'd1,
        HO_ACTIVE = 2'd2
    } ho_state_e;

    typedef struct packed {
        logic lock_restart;
        logic holdover;
        logic lock_drop;
        logic watchdog;
        logic stability;
        logic function_;
        logic holdover_dm;
    } wr_hit_t;

    function automatic wr_hit_t decode_class(input logic en, input wr_class_t cls);
        wr_hit_t h;
        h.lock_restart = en && (cls == CLS_LOCK_RESTART);
        h.holdover     = en && (cls == CLS_HOLDOVER);
        h.lock_drop    = en && (cls == CLS_LOCK_DROP);
        h.watchdog     = en && (cls == CLS_WATCHDOG);
        h.stability    = en && (cls == CLS_STABILITY);
        h.function_    = en && (cls == CLS_FUNCTION);
        h.holdover_dm  = en && (cls == CLS_HOLDOVER_DM);
        return h;
    endfunction

endpackage

// File: rtl/wdet_hold_ctl.sv
module wdet_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic upd_i,
    input  logic gate_i,
    output logic hold_o,
    output logic resume_o
);
    logic held_q, wait_q, resume_q;
    logic held_n, wait_n, resume_n;

    always_comb begin
        held_n   = held_q;
        wait_n   = wait_q;
        resume_n = 1'b0;
        if (upd_i && held_q) begin
            held_n = 1'b0;
            if (gate_i) resume_n = 1'b1;
            else        wait_n   = 1'b1;
        end else if (wait_q && gate_i) begin
            wait_n   = 1'b0;
            resume_n = 1'b1;
        end
        if (arm_i) begin
            held_n   = 1'b1;
            wait_n   = 1'b0;
            resume_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            wait_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            held_q   <= held_n;
            wait_q   <= wait_n;
            resume_q <= resume_n;
        end
    end

    assign hold_o   = held_q | wait_q;
    assign resume_o = resume_q;

    AST_RESUME_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> $past(hold_o)); // R8
    AST_HOLD_AFTER_ARM: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (hold_o && !resume_o)); // R10

endmodule

// File: rtl/wdet_holdover.sv
module wdet_holdover
    import wdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic upd_i,
    input  logic tick_i,
    output logic req_o
);
    logic      armed_q;
    ho_state_e st_q, st_n;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            HO_ALIGN:  if (tick_i) st_n = HO_ACTIVE;
            HO_ACTIVE: if (tick_i) st_n = HO_IDLE;
            default:   st_n = HO_IDLE;
        endcase
        if (upd_i && armed_q) st_n = HO_ALIGN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            st_q    <= HO_IDLE;
        end else begin
            st_q <= st_n;
            if (arm_i)                armed_q <= 1'b1;
            else if (upd_i && armed_q) armed_q <= 1'b0;
        end
    end

    assign req_o = (st_q == HO_ACTIVE);

    AST_HO_OPEN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(tick_i)); // R3
    AST_HO_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (req_o && tick_i && !(upd_i && armed_q)) |=> !req_o); // R3

endmodule

// File: rtl/wdet_ctrl.sv
module wdet_ctrl
    import wdet_pkg::*;
#(
    parameter int CLASS_BITS = CLASS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CLASS_BITS-1:0] wr_class,
    input  logic                  wr_sel_ref,
    input  logic                  wr_func_assigned,
    input  logic                  upd_stb,
    input  logic                  demap_mode,
    input  logic                  sysclk_locked,
    input  logic                  pfd_tick,
    output logic                  lock_unlock,
    output logic                  lock_hold,
    output logic                  lock_restart,
    output logic                  wdog_hold,
    output logic                  wdog_resume,
    output logic                  stab_hold,
    output logic                  stab_resume,
    output logic                  holdover_req,
    output logic                  func_stop,
    output logic                  func_start
);
    wr_hit_t hit;
    logic    ho_arm;
    logic    unlock_q, stop_q, start_q, func_armed_q;

    assign hit    = decode_class(wr_en, wr_class_t'(wr_class));
    assign ho_arm = (hit.holdover && wr_sel_ref) ||
                    (hit.holdover_dm && wr_sel_ref && demap_mode);

    wdet_hold_ctl u_lock (
        .clk(clk), .rst(rst), .arm_i(hit.lock_restart), .upd_i(upd_stb),
        .gate_i(1'b1), .hold_o(lock_hold), .resume_o(lock_restart));

    wdet_hold_ctl u_wdog (
        .clk(clk), .rst(rst), .arm_i(hit.watchdog), .upd_i(upd_stb),
        .gate_i(1'b1), .hold_o(wdog_hold), .resume_o(wdog_resume));

    wdet_hold_ctl u_stab (
        .clk(clk), .rst(rst), .arm_i(hit.stability), .upd_i(upd_stb),
        .gate_i(sysclk_locked), .hold_o(stab_hold), .resume_o(stab_resume));

    wdet_holdover u_ho (
        .clk(clk), .rst(rst), .arm_i(ho_arm), .upd_i(upd_stb),
        .tick_i(pfd_tick), .req_o(holdover_req));

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q     <= 1'b0;
            stop_q       <= 1'b0;
            start_q      <= 1'b0;
            func_armed_q <= 1'b0;
        end else begin
            unlock_q <= hit.lock_restart | hit.lock_drop;
            stop_q   <= hit.function_ & wr_func_assigned;
            start_q  <= upd_stb & func_armed_q;
            if (hit.function_)               func_armed_q <= 1'b1;
            else if (upd_stb && func_armed_q) func_armed_q <= 1'b0;
        end
    end

    assign lock_unlock = unlock_q;
    assign func_stop   = stop_q;
    assign func_start  = start_q;

    AST_UNLOCK_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_class == CLASS_BITS'(1) || wr_class == CLASS_BITS'(3))) |=> lock_unlock); // R1
    AST_RESTART_ENDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        lock_restart |-> (!lock_hold && $past(lock_hold))); // R2
    AST_WDOG_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class == CLASS_BITS'(5)) |=> wdog_hold); // R5
    AST_STAB_RESUME_LOCKED: assert property (@(posedge clk) disable iff (rst)
        stab_resume |-> $past(sysclk_locked)); // R6
    AST_FUNC_STOP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class == CLASS_BITS'(7) && wr_func_assigned) |=> func_stop); // R7
    AST_START_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        func_start |-> $past(upd_stb)); // R7

endmodule

// File: tb/wdet_ctrl_tb.sv
module wdet_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_sel_ref, wr_func_assigned, upd_stb;
    logic       demap_mode, sysclk_locked, pfd_tick;
    logic [3:0] wr_class;
    logic lock_unlock, lock_hold, lock_restart, wdog_hold, wdog_resume;
    logic stab_hold, stab_resume, holdover_req, func_stop, func_start;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdet_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_class(wr_class),
        .wr_sel_ref(wr_sel_ref), .wr_func_assigned(wr_func_assigned),
        .upd_stb(upd_stb), .demap_mode(demap_mode),
        .sysclk_locked(sysclk_locked), .pfd_tick(pfd_tick),
        .lock_unlock(lock_unlock), .lock_hold(lock_hold),
        .lock_restart(lock_restart), .wdog_hold(wdog_hold),
        .wdog_resume(wdog_resume), .stab_hold(stab_hold),
        .stab_resume(stab_resume), .holdover_req(holdover_req),
        .func_stop(func_stop), .func_start(func_start));

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] cls, input logic sel, input logic asg, input logic upd);
        wr_en = 1'b1; wr_class = cls; wr_sel_ref = sel; wr_func_assigned = asg; upd_stb = upd;
        cyc();
        wr_en = 1'b0; wr_class = 4'd0; wr_sel_ref = 1'b0; wr_func_assigned = 1'b0; upd_stb = 1'b0;
    endtask

    task automatic upd();
        upd_stb = 1'b1; cyc(); upd_stb = 1'b0;
    endtask

    task automatic tick();
        pfd_tick = 1'b1; cyc(); pfd_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 unlock", lock_unlock, 1'b0);
        chk("R11 lock_hold", lock_hold, 1'b0);
        chk("R11 holdover", holdover_req, 1'b0);
        chk("R11 any", |{lock_restart, wdog_hold, wdog_resume, stab_hold,
                         stab_resume, func_stop, func_start}, 1'b0);
    endtask

    task automatic t_lock();
        wr(4'd1, 0, 0, 0);
        chk("R1 unlock class1", lock_unlock, 1'b1);
        chk("R2 hold set", lock_hold, 1'b1);
        cyc();
        chk("R1 unlock one cycle", lock_unlock, 1'b0);
        chk("R2 hold kept", lock_hold, 1'b1);
        upd();
        chk("R2 restart pulse", lock_restart, 1'b1);
        chk("R2 hold cleared", lock_hold, 1'b0);
        cyc();
        chk("R2 restart one cycle", lock_restart, 1'b0);
        wr(4'd3, 0, 0, 0);
        chk("R1 unlock class3", lock_unlock, 1'b1);
        chk("R2 class3 no hold", lock_hold, 1'b0);
        wr(4'd4, 0, 0, 0);
        chk("R1 class4 no unlock", lock_unlock, 1'b0);
        wr(4'd2, 0, 0, 0);
        chk("R1 class2 no unlock", lock_unlock, 1'b0);
        cyc();
    endtask

    task automatic t_holdover();
        wr(4'd2, 1, 0, 0);
        upd();
        chk("R3 not before tick", holdover_req, 1'b0);
        cyc(); cyc();
        chk("R3 waits for tick", holdover_req, 1'b0);
        tick();
        chk("R3 opens after tick", holdover_req, 1'b1);
        cyc(); cyc(); cyc();
        chk("R3 held in period", holdover_req, 1'b1);
        tick();
        chk("R3 closes after next tick", holdover_req, 1'b0);
    endtask

    task automatic t_ho_block(input logic [3:0] cls, input logic sel, input logic dm,
                              input logic exp, input string tag);
        logic seen;
        seen = 1'b0;
        demap_mode = dm;
        wr(cls, sel, 0, 0);
        demap_mode = 1'b0;
        upd();
        for (int i = 0; i < 2; i++) begin
            tick();
            seen |= holdover_req;
            cyc();
            seen |= holdover_req;
        end
        chk(tag, seen, exp);
    endtask

    task automatic t_wdog();
        wr(4'd5, 0, 0, 0);
        chk("R5 hold", wdog_hold, 1'b1);
        cyc();
        chk("R5 no early resume", wdog_resume, 1'b0);
        upd();
        chk("R5 resume", wdog_resume, 1'b1);
        chk("R5 hold cleared", wdog_hold, 1'b0);
        cyc();
        chk("R5 resume one cycle", wdog_resume, 1'b0);
    endtask

    task automatic t_stab();
        sysclk_locked = 1'b0;
        wr(4'd6, 0, 0, 0);
        chk("R6 hold", stab_hold, 1'b1);
        upd();
        chk("R6 no resume unlocked", stab_resume, 1'b0);
        repeat (4) cyc();
        chk("R6 still held", stab_hold, 1'b1);
        chk("R6 still no resume", stab_resume, 1'b0);
        sysclk_locked = 1'b1;
        cyc();
        chk("R6 resume on lock", stab_resume, 1'b1);
        chk("R6 hold cleared", stab_hold, 1'b0);
        cyc();
        wr(4'd6, 0, 0, 0);
        upd();
        chk("R6 resume at update when locked", stab_resume, 1'b1);
        cyc();
    endtask

    task automatic t_func();
        wr(4'd7, 0, 1, 0);
        chk("R7 stop assigned", func_stop, 1'b1);
        upd();
        chk("R7 start", func_start, 1'b1);
        cyc();
        chk("R7 start one cycle", func_start, 1'b0);
        wr(4'd7, 0, 0, 0);
        chk("R7 no stop unassigned", func_stop, 1'b0);
        upd();
        chk("R7 start unassigned", func_start, 1'b1);
        cyc();
    endtask

    task automatic t_multi();
        wr(4'd1, 0, 0, 0);
        wr(4'd1, 0, 0, 0);
        wr(4'd5, 0, 0, 0);
        wr(4'd7, 0, 0, 0);
        wr(4'd5, 0, 0, 0);
        upd();
        chk("R9 lock restart together", lock_restart, 1'b1);
        chk("R9 wdog resume together", wdog_resume, 1'b1);
        chk("R9 func start together", func_start, 1'b1);
        cyc();
        upd();
        chk("R8 no second restart", lock_restart, 1'b0);
        chk("R8 no second resume", wdog_resume, 1'b0);
        chk("R8 no second start", func_start, 1'b0);
    endtask

    task automatic t_same();
        wr(4'd5, 0, 0, 1);
        chk("R10 armed not serviced", wdog_resume, 1'b0);
        chk("R10 hold set", wdog_hold, 1'b1);
        upd();
        chk("R10 serviced next update", wdog_resume, 1'b1);
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_class = 4'd0; wr_sel_ref = 1'b0;
        wr_func_assigned = 1'b0; upd_stb = 1'b0; demap_mode = 1'b0;
        sysclk_locked = 1'b1; pfd_tick = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_lock();
        t_holdover();
        t_ho_block(4'd2, 1'b0, 1'b0, 1'b0, "R4 class2 other ref");
        t_ho_block(4'd8, 1'b1, 1'b0, 1'b0, "R4 class8 no demap");
        t_ho_block(4'd8, 1'b0, 1'b1, 1'b0, "R4 class8 other ref");
        t_ho_block(4'd8, 1'b1, 1'b1, 1'b1, "R4 class8 demap fires");
        t_wdog();
        t_stab();
        t_func();
        t_multi();
        t_same();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule